// File: doc/BRIEF.md
# Single-Precision to Signed Integer Converter

This block turns an IEEE 754 single-precision operand into a signed 32-bit integer. On every cycle where `in_valid` is high it samples the operand and a two-bit rounding selector. One clock later it presents the integer on `out_int` and raises `out_valid`. The selector chooses between rounding toward zero, toward minus infinity, toward plus infinity, and to nearest with ties going to the even integer.

Alongside the result the block keeps four sticky exception flags: invalid, inexact, underflow and overflow. A conversion can only set these flags. The only ways to bring them back to zero are reset and the synchronous `flag_clr` input. When a conversion cannot produce a meaningful integer, the result is replaced by the constant 0x7FFFFFFF. This happens when the operand is NaN or infinite, or when the rounded value falls outside the signed 32-bit range. An out-of-range conversion always raises invalid together with overflow.

The latency is exactly one clock from `in_valid` to `out_valid`. The exception flags are updated on that same edge.

Top module: `fcvt_f2i`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low. `out_int` carries the result of that input.
- R2: While `rst` is high at a clock edge, `out_valid`, `out_int` and all four flags become zero.
- R3: `in_mode` encoding: 0 rounds toward zero, 1 toward minus infinity, 2 toward plus infinity, 3 to nearest. The result is the rounded integral value as a two's-complement 32-bit integer.
- R4: In mode 3, an operand exactly halfway between two integers converts to the even one (for example 2.5 gives 2 and -1.5 gives -2).
- R5: The inexact flag (flag_inexact) is set when the rounded value differs from the operand. An operand that is already integral leaves it untouched.
- R6: A NaN operand sets invalid and inexact, since a NaN never equals its rounded value. An infinite operand sets invalid and overflow. In both cases `out_int` is 0x7FFFFFFF.
- R7: A rounded value above 2147483647 or below -2147483648 sets both overflow and invalid and yields 0x7FFFFFFF. The operand -2^31 (encoding 0xCF000000) converts to 0x80000000 and sets no flag.
- R8: The underflow flag is set only by a nonzero rounded value below the smallest normal magnitude. A rounded integral value never meets this condition, so subnormal operands convert to 0 or ±1 and leave underflow clear.
- R9: The flags are sticky. A later conversion with no exception does not clear a flag set earlier.
- R10: `flag_clr` high at a clock edge clears all four flags. If a conversion happens in the same cycle, the clear wins, while the conversion result is still delivered.
- R11: With `in_valid` and `flag_clr` both low, the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_mode | input | 2 | Rounding selector (0 zero, 1 down, 2 up, 3 nearest-even) |
| in_float | input | 32 | Single-precision operand |
| flag_clr | input | 1 | Synchronous clear of the sticky flags |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_int | output | 32 | Signed integer result or 0x7FFFFFFF |
| flag_invalid | output | 1 | Sticky invalid-conversion flag |
| flag_inexact | output | 1 | Sticky inexact flag |
| flag_underflow | output | 1 | Sticky underflow flag |
| flag_overflow | output | 1 | Sticky overflow flag |

## Verification
The hardest corners to reach from the ports are the edges of the integer range. The operand -2^31 must convert cleanly, while +2^31 and the largest float just below it must land on opposite sides of the overflow rule. These need exact operand encodings, so the stimulus drives them directly in every rounding mode. It does the same for halfway values of both signs and for subnormal operands. A pseudo-random sweep then sets the exponent near the point where operands stop carrying fraction bits. That sweep runs conversions back to back, so sticky accumulation across many results is compared as well. One conversion is issued together with `flag_clr` to exercise the collision rule.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

  // Rounding selector carried on in_mode.
  typedef enum logic [1:0] {
    RM_TOWARD_ZERO  = 2'd0,
    RM_DOWN         = 2'd1,
    RM_UP           = 2'd2,
    RM_NEAREST_EVEN = 2'd3
  } rmode_e;

  // Exception indications produced by one conversion.
  typedef struct packed {
    logic invalid;
    logic inexact;
    logic underflow;
    logic overflow;
  } xflags_t;

endpackage

// File: rtl/fcvt_unpack.sv
// Splits a binary floating-point word into sign, effective exponent and
// significand (hidden bit restored), and classifies the special encodings.
module fcvt_unpack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] word_i,
  output logic                 sign_o,
  output logic [EXP_W-1:0]     exp_o,
  output logic [MAN_W:0]       sig_o,
  output logic                 frac_zero_o,
  output logic                 nonfinite_o,
  output logic                 nan_o
);
  logic [EXP_W-1:0] raw_exp;
  logic [MAN_W-1:0] frac;
  logic             exp_zero;

  assign sign_o      = word_i[EXP_W+MAN_W];
  assign raw_exp     = word_i[EXP_W+MAN_W-1:MAN_W];
  assign frac        = word_i[MAN_W-1:0];
  assign exp_zero    = (raw_exp == '0);
  assign frac_zero_o = (frac == '0);
  assign nonfinite_o = (raw_exp == '1);
  assign nan_o       = nonfinite_o & ~frac_zero_o;

  // Subnormals share the scale of the smallest normal exponent.
  assign exp_o = exp_zero ? EXP_W'(1) : raw_exp;
  assign sig_o = {~exp_zero, frac};
endmodule

// File: rtl/fcvt_align.sv
// Places the significand on the integer grid: the integral magnitude, the
// first dropped bit (guard) and the OR of all lower dropped bits (sticky).
module fcvt_align #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W:0]   sig_i,
  output logic [INT_W-1:0] mag_o,
  output logic             guard_o,
  output logic             sticky_o,
  output logic             too_big_o,
  output logic             at_limit_o
);
  localparam int SIG_W      = MAN_W + 1;
  localparam int BIAS       = (1 << (EXP_W - 1)) - 1;
  localparam int INTEGRAL_E = BIAS + MAN_W;      // from here on no fraction bits
  localparam int LIMIT_E    = BIAS + INT_W - 1;  // magnitude reaches 2^(INT_W-1)
  localparam int EXT_W      = 2 * SIG_W + 1;

  int                 e_val;
  int                 rsh;
  logic [EXT_W-1:0]   ext;
  logic [INT_W-1:0]   right_mag;
  logic               right_g;
  logic               right_s;
  logic [INT_W-1:0]   left_mag;

  assign e_val      = int'(exp_i);
  assign too_big_o  = (e_val >= LIMIT_E);
  assign at_limit_o = (e_val == LIMIT_E) && (sig_i[MAN_W-1:0] == '0);

  // Fractional operands: shift right, keep guard and sticky.
  always_comb begin
    rsh = INTEGRAL_E - e_val;
    ext = '0;
    if (rsh > SIG_W) begin
      right_mag = '0;
      right_g   = 1'b0;
      right_s   = |sig_i;
    end else begin
      ext       = {sig_i, {(SIG_W + 1){1'b0}}} >> rsh;
      right_mag = INT_W'(ext[EXT_W-1 -: SIG_W]);
      right_g   = ext[SIG_W];
      right_s   = |ext[SIG_W-1:0];
    end
  end

  // Integral operands that still fit: present only when the integer is wider
  // than the significand.
  generate
    if (LIMIT_E > INTEGRAL_E) begin : g_left
      int lsh;
      always_comb begin
        lsh      = e_val - INTEGRAL_E;
        left_mag = INT_W'(sig_i) << lsh;
      end
    end else begin : g_no_left
      assign left_mag = '0;
    end
  endgenerate

  always_comb begin
    if (e_val < INTEGRAL_E) begin
      mag_o    = right_mag;
      guard_o  = right_g;
      sticky_o = right_s;
    end else begin
      mag_o    = left_mag;
      guard_o  = 1'b0;
      sticky_o = 1'b0;
    end
  end
endmodule

// File: rtl/fcvt_round.sv
// Applies the selected rounding to an aligned magnitude and restores sign.
module fcvt_round
  import fcvt_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  rmode_e           mode_i,
  input  logic             sign_i,
  input  logic [INT_W-1:0] mag_i,
  input  logic             guard_i,
  input  logic             sticky_i,
  output logic [INT_W-1:0] value_o,
  output logic             inexact_o
);
  logic             lost;
  logic             bump;
  logic [INT_W-1:0] mag_r;

  assign lost = guard_i | sticky_i;

  always_comb begin
    unique case (mode_i)
      RM_TOWARD_ZERO:  bump = 1'b0;
      RM_DOWN:         bump = sign_i & lost;
      RM_UP:           bump = ~sign_i & lost;
      RM_NEAREST_EVEN: bump = guard_i & (sticky_i | mag_i[0]);
      default:         bump = 1'b0;
    endcase
  end

  assign mag_r     = mag_i + INT_W'(bump);
  assign value_o   = sign_i ? (~mag_r + INT_W'(1)) : mag_r;
  assign inexact_o = lost;
endmodule

// File: rtl/fcvt_f2i.sv
// Float-to-integer converter: one register stage, sticky exception flags.
module fcvt_f2i
  import fcvt_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [1:0]           in_mode,
  input  logic [EXP_W+MAN_W:0] in_float,
  input  logic                 flag_clr,
  output logic                 out_valid,
  output logic [INT_W-1:0]     out_int,
  output logic                 flag_invalid,
  output logic                 flag_inexact,
  output logic                 flag_underflow,
  output logic                 flag_overflow
);
  localparam logic [INT_W-1:0] BAD_RESULT = {1'b0, {(INT_W - 1){1'b1}}};
  localparam logic [INT_W-1:0] MOST_NEG   = {1'b1, {(INT_W - 1){1'b0}}};

  logic             op_sign;
  logic [EXP_W-1:0] op_exp;
  logic [MAN_W:0]   op_sig;
  logic             op_frac_zero;
  logic             op_nonfinite;
  logic             op_nan;
  logic [INT_W-1:0] al_mag;
  logic             al_guard;
  logic             al_sticky;
  logic             al_too_big;
  logic             al_at_limit;
  logic [INT_W-1:0] rd_value;
  logic             rd_inexact;
  logic             is_most_neg;
  logic             out_of_range;
  xflags_t          now_flags;
  xflags_t          sticky_q;
  logic [INT_W-1:0] result_d;

  fcvt_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
    .word_i      (in_float),
    .sign_o      (op_sign),
    .exp_o       (op_exp),
    .sig_o       (op_sig),
    .frac_zero_o (op_frac_zero),
    .nonfinite_o (op_nonfinite),
    .nan_o       (op_nan)
  );

  fcvt_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_align (
    .exp_i      (op_exp),
    .sig_i      (op_sig),
    .mag_o      (al_mag),
    .guard_o    (al_guard),
    .sticky_o   (al_sticky),
    .too_big_o  (al_too_big),
    .at_limit_o (al_at_limit)
  );

  fcvt_round #(.INT_W(INT_W)) u_round (
    .mode_i    (rmode_e'(in_mode)),
    .sign_i    (op_sign),
    .mag_i     (al_mag),
    .guard_i   (al_guard),
    .sticky_i  (al_sticky),
    .value_o   (rd_value),
    .inexact_o (rd_inexact)
  );

  // The most negative integer is the only in-range magnitude of 2^(INT_W-1).
  assign is_most_neg  = op_sign & al_at_limit;
  // Infinity compares above every integer; NaN compares with nothing.
  assign out_of_range = (op_nonfinite & op_frac_zero)
                      | (~op_nonfinite & al_too_big & ~is_most_neg);

  always_comb begin
    now_flags.overflow  = out_of_range;
    now_flags.invalid   = op_nonfinite | out_of_range;
    now_flags.inexact   = op_nan | (~op_nonfinite & ~al_too_big & rd_inexact);
    // A rounded integral value is zero or at least one in magnitude, so it
    // never lies in the subnormal range.
    now_flags.underflow = 1'b0;
  end

  always_comb begin
    if (now_flags.invalid)  result_d = BAD_RESULT;
    else if (is_most_neg)   result_d = MOST_NEG;
    else                    result_d = rd_value;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_int   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_int <= result_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flag_clr) sticky_q <= '0;
    else if (in_valid)   sticky_q <= sticky_q | now_flags;
  end

  assign flag_invalid   = sticky_q.invalid;
  assign flag_inexact   = sticky_q.inexact;
  assign flag_underflow = sticky_q.underflow;
  assign flag_overflow  = sticky_q.overflow;
endmodule

// File: rtl/fcvt_f2i_chk.sv
module fcvt_f2i_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [EXP_W+MAN_W:0] in_float,
  input logic                 flag_clr,
  input logic                 out_valid,
  input logic [INT_W-1:0]     out_int,
  input logic                 flag_invalid,
  input logic                 flag_inexact,
  input logic                 flag_underflow,
  input logic                 flag_overflow
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [INT_W-1:0] BAD_RESULT = {1'b0, {(INT_W - 1){1'b1}}};
  localparam logic [INT_W-1:0] MOST_NEG   = {1'b1, {(INT_W - 1){1'b0}}};
  localparam logic [EXP_W+MAN_W:0] NEG_LIMIT_F =
    {1'b1, EXP_W'(BIAS + INT_W - 1), {MAN_W{1'b0}}};

  logic [3:0] flags;
  logic       in_is_nan;
  assign flags     = {flag_invalid, flag_inexact, flag_underflow, flag_overflow};
  assign in_is_nan = (in_float[EXP_W+MAN_W-1:MAN_W] == '1) && (in_float[MAN_W-1:0] != '0);

  AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (!out_valid && out_int == '0 && flags == 4'b0)); // R2
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R1
  AST_NAN_INVALID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !flag_clr && in_is_nan) |=> (flag_invalid && out_int == BAD_RESULT)); // R6
  AST_MOST_NEG_OK: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_float == NEG_LIMIT_F) |=> (out_int == MOST_NEG)); // R7
  AST_OVF_WITH_INV: assert property (@(posedge clk) disable iff (rst) flag_overflow |-> flag_invalid); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) in_valid |=> !flag_underflow); // R8
  AST_STICKY_INV: assert property (@(posedge clk) disable iff (rst) (!flag_clr && flag_invalid) |=> flag_invalid); // R9
  AST_STICKY_INX: assert property (@(posedge clk) disable iff (rst) (!flag_clr && flag_inexact) |=> flag_inexact); // R9
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst) flag_clr |=> (flags == 4'b0)); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) (!in_valid && !flag_clr) |=> $stable(flags)); // R11
endmodule

bind fcvt_f2i fcvt_f2i_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .in_float       (in_float),
  .flag_clr       (flag_clr),
  .out_valid      (out_valid),
  .out_int        (out_int),
  .flag_invalid   (flag_invalid),
  .flag_inexact   (flag_inexact),
  .flag_underflow (flag_underflow),
  .flag_overflow  (flag_overflow)
);

// File: tb/fcvt_f2i_test.sv
module fcvt_f2i_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BAD = 32'h7FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  in_mode;
  logic [31:0] in_float;
  logic        flag_clr;
  logic        out_valid;
  logic [31:0] out_int;
  logic        flag_invalid, flag_inexact, flag_underflow, flag_overflow;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fcvt_f2i uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_float(in_float), .flag_clr(flag_clr), .out_valid(out_valid),
    .out_int(out_int), .flag_invalid(flag_invalid), .flag_inexact(flag_inexact),
    .flag_underflow(flag_underflow), .flag_overflow(flag_overflow)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] q_res[$];
  logic [3:0]  q_flg[$];
  string       q_tag[$];
  logic [3:0]  mflags = 4'b0;  // {invalid, inexact, underflow, overflow}

  function automatic logic [3:0] port_flags();
    return {flag_invalid, flag_inexact, flag_underflow, flag_overflow};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic real fval(input logic [31:0] b);
    int  e2;
    real m;
    real p;
    m  = (b[30:23] == 8'd0) ? real'(b[22:0]) : real'(b[22:0]) + 8388608.0;
    e2 = ((b[30:23] == 8'd0) ? 1 : int'(b[30:23])) - 150;
    p  = 1.0;
    if (e2 >= 0) for (int i = 0; i < e2; i++) p = p * 2.0;
    else for (int i = 0; i < -e2; i++) p = p / 2.0;
    return b[31] ? -(m * p) : (m * p);
  endfunction

  task automatic model(input logic [31:0] b, input logic [1:0] op,
                       output logic [31:0] res, output logic [3:0] f);
    real x;
    real r;
    f = 4'b0;
    if (b[30:23] == 8'hFF) begin
      res = BAD;
      f   = (b[22:0] != 0) ? 4'b1100 : 4'b1001;
      return;
    end
    x = fval(b);
    case (op)
      2'd0: r = (x < 0.0) ? $ceil(x) : $floor(x);
      2'd1: r = $floor(x);
      2'd2: r = $ceil(x);
      default: begin
        r = $floor(x + 0.5);
        if ((r - x) == 0.5 && (longint'(r) % 2 != 0)) r = r - 1.0;
      end
    endcase
    if (r != x) f[2] = 1'b1;
    if (r > 2147483647.0 || r < -2147483648.0) begin
      f[3] = 1'b1;
      f[0] = 1'b1;
      res  = BAD;
    end else begin
      res = 32'(longint'(r));
    end
  endtask

  task automatic send(input logic [31:0] b, input logic [1:0] op, input bit clr, input string tag);
    logic [31:0] r;
    logic [3:0]  f;
    model(b, op, r, f);
    if (clr) mflags = 4'b0;
    else     mflags = mflags | f;
    q_res.push_back(r);
    q_flg.push_back(mflags);
    q_tag.push_back($sformatf("%s op%0d in=%h", tag, op, b));
    in_float = b;
    in_mode  = op;
    in_valid = 1'b1;
    flag_clr = clr;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    flag_clr = 1'b0;
  endtask

  task automatic clear_only();
    flag_clr = 1'b1;
    mflags   = 4'b0;
    @(posedge clk);
    #1;
    flag_clr = 1'b0;
    @(negedge clk);
    check("R10 flags after clear", {28'b0, port_flags()}, 32'b0);
  endtask

  // Monitor: compare each delivered result with the next expected item.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_res.size() == 0) begin
        check("R1 out_valid without pending input", 32'd1, 32'd0);
      end else begin
        logic [31:0] r;
        logic [3:0]  f;
        string       t;
        r = q_res.pop_front();
        f = q_flg.pop_front();
        t = q_tag.pop_front();
        check({t, " result"}, out_int, r);
        check({t, " flags"}, {28'b0, port_flags()}, {28'b0, f});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  logic [31:0] dir [24] = '{
    32'h3F800000, 32'h3FC00000, 32'h40200000, 32'hBFC00000, 32'hC0200000,
    32'h3F000000, 32'hBF000000, 32'hC0300000, 32'h00000000, 32'h80000000,
    32'h40600000, 32'h7F800000, 32'hFF800000, 32'h7FC00000, 32'h4F000000,
    32'hCF000000, 32'h4EFFFFFF, 32'hCEFFFFFF, 32'h4F32D05E, 32'h7F7FFFFF,
    32'h00000001, 32'h80000001, 32'h00800000, 32'h3EFFFFFF
  };

  initial begin
    logic [31:0] st;
    logic [3:0]  held;
    rst      = 1'b1;
    in_valid = 1'b0;
    in_mode  = 2'd0;
    in_float = 32'b0;
    flag_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 out_valid in reset", {31'b0, out_valid}, 32'b0);
    check("R2 flags in reset", {28'b0, port_flags()}, 32'b0);
    check("R2 out_int in reset", out_int, 32'b0);
    @(posedge clk);
    #1;
    rst = 1'b0;

    // R3 R4 R5 R6 R7 R8: every directed operand in every mode, flags fresh.
    for (int op = 0; op < 4; op++) begin
      foreach (dir[i]) begin
        clear_only();
        send(dir[i], 2'(op), 1'b0, "R3 R4 R5 R6 R7 R8 directed");
      end
    end

    // R9: NaN then a clean integer; invalid and inexact must persist.
    clear_only();
    send(32'h7FC00000, 2'd0, 1'b0, "R9 NaN");
    send(32'h40E00000, 2'd0, 1'b0, "R9 sticky after clean");

    // R10: conversion together with clear; result delivered, flags zero.
    send(32'h7F800000, 2'd1, 1'b1, "R10 clear with conversion");

    // R11: idle cycles keep flags and produce no result.
    clear_only();
    send(32'h3FC00000, 2'd3, 1'b0, "R11 setup");
    held = mflags;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 flags held while idle", {28'b0, port_flags()}, {28'b0, held});
    check("R1 no out_valid while idle", {31'b0, out_valid}, 32'b0);

    // Sweep around the integral threshold, back to back, sticky accumulating.
    st = 32'h1234_5678;
    for (int k = 0; k < 400; k++) begin
      logic [7:0] e;
      st = st ^ (st << 13);
      st = st ^ (st >> 17);
      st = st ^ (st << 5);
      e  = 8'(100 + (st % 72));
      if (k % 16 == 0) clear_only();
      send({st[31], e, st[22:0]}, st[9:8], 1'b0, "R3 R5 R7 R9 sweep");
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 every input produced one result", q_res.size(), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule